// File: doc/BRIEF.md
# Coherence Notification Way Filter

This block sits beside each private cache and listens to a narrow serial broadcast channel. A notification arrives as a short burst of beats. The block rebuilds the message and decodes its two-bit action code. It then tells the cache which ways of the addressed set must drop their copy or give up ownership. The cache answers the block's set lookup with the tag, the coherence state and a private flag for every way of that set. The block returns one-cycle strobes per way.

Two message formats are available, chosen by the `FWD_MODE` parameter. The compact format carries only the set index and five low tag bits, so one notice can hit several ways of a set. The state filter and the private-block filter keep that over-reach small. The forwarding format carries the full block address and the requester number. An owning way that matches also raises a forward request, so the cache can send the line straight to the requester. Storage for tags and data stays in the cache.

Top module: `coh_notify_filter`

## Requirements
- R1: After reset, `lookup_valid`, all strobes and `fwd_valid` are low until a complete message has arrived.
- R2: A message is NBEATS beats long: 5 in compact mode, 11 in forwarding mode, with 3 bits per beat. The first beat is flagged by `beat_sop`. Bits arrive most significant first, and the last beat ends with one unused pad bit. In the cycle after the clock edge that takes the last beat, `lookup_valid` is high for exactly one cycle, and `lookup_set` shows the message's set index.
- R3: Valid beats without `beat_sop` are ignored while no message is open. A beat with `beat_sop` in the middle of a message drops the partial message and starts a new one.
- R4: The compact layout is {code[1:0], index[6:0], extra[4:0]}. Code 00 invalidates owner ways, 01 invalidates sharer ways and 10 downgrades owner ways. Code 11 changes nothing.
- R5: In compact mode, a way can be selected only if `extra` equals bits [4:0] of its tag. Ways whose tags differ only above bit 4 are all selected.
- R6: State encoding per way is I=00, S=01, E=10, M=11. Owner invalidate and downgrade actions touch only ways in E or M.
- R7: A sharer invalidation touches only ways in S.
- R8: A way whose `way_private` bit is set is never strobed and is never named in a forward request.
- R9: The forwarding layout is {code[1:0], requester[3:0], tag[18:0], index[6:0]}, and a way must match all 19 tag bits. Code 00 invalidates sharers, 01 downgrades owners with a forward, and 10 invalidates owners with a forward. Code 11 changes nothing.
- R10: In forwarding mode, code 01 or 10 raises `fwd_valid` in the same cycle as the strobes, but only when at least one owner way passes all filters. `fwd_way` is then one-hot on the lowest such way, `fwd_id` carries the requester, and `fwd_inval` is high for code 10.
- R11: A way is never given an invalidate strobe and a downgrade strobe in the same cycle. Strobes last one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| beat_valid | input | 1 | A beat is present on the channel |
| beat_sop | input | 1 | This beat opens a message |
| beat_data | input | 3 | Beat bits |
| lookup_valid | output | 1 | A message is complete and the set must be presented |
| lookup_set | output | 7 | Set index of the complete message |
| way_tag | input | 76 | Tag of every way of the looked-up set, way 0 in the low bits |
| way_state | input | 8 | Two-bit coherence state per way |
| way_private | input | 4 | Way holds a block classed as private |
| inv_way | output | 4 | Per-way invalidate strobe |
| dgr_way | output | 4 | Per-way downgrade-to-shared strobe |
| fwd_valid | output | 1 | Forward request (forwarding mode only) |
| fwd_way | output | 4 | One-hot owner way to forward from |
| fwd_id | output | 4 | Requester number to forward to |
| fwd_inval | output | 1 | Forward also invalidates the owner copy |

## Verification
Two things can fall in the same cycle. One is the decision for a finished message. The other is the first beat of the next message, or a stray beat, arriving in the one cycle that `lookup_valid` is high. The bench drives messages back to back so that a new opening beat lands in that decision cycle. The strobes and `lookup_set` must still match the message that just finished, and the next message must decode correctly as well. The same cycle also joins several per-way filters. Random sets mix partial-tag hits, all four states and private flags, so one notice can strobe some ways and leave others alone, and each way is compared with a bench model.

// File: rtl/cnf_pkg.sv
// Shared definitions for the coherence notification way filter.
// Assumes a two-bit per-way coherence state, encoded as below.
package cnf_pkg;
    typedef enum logic [1:0] {
        ST_I = 2'b00,
        ST_S = 2'b01,
        ST_E = 2'b10,
        ST_M = 2'b11
    } mesi_e;

    localparam int CODE_W = 2;
endpackage

// File: rtl/cnf_deser.sv
// Beat collector: gathers NBEATS beats, most significant first, into one
// message and pulses msg_done for one cycle after the final beat.
// Assumes the padded message needs at least two beats.
module cnf_deser #(
    parameter int BEAT_W = 3,
    parameter int MSG_W  = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             beat_valid,
    input  logic             beat_sop,
    input  logic [BEAT_W-1:0] beat_data,
    output logic             msg_done,
    output logic [MSG_W-1:0] msg
);
    localparam int NBEATS = (MSG_W + BEAT_W - 1) / BEAT_W;
    localparam int SH_W   = NBEATS * BEAT_W;
    localparam int CNT_W  = $clog2(NBEATS + 1);

    logic [SH_W-1:0]  sh_q;
    logic [SH_W-1:0]  sh_next;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_next;
    logic             take;

    // Decide whether this beat belongs to a message and where it lands.
    always_comb begin
        take     = beat_valid && (beat_sop || (cnt_q != '0));
        cnt_next = beat_sop ? CNT_W'(1) : cnt_q + CNT_W'(1);
        sh_next  = {sh_q[SH_W-BEAT_W-1:0], beat_data};
    end

    // Shift beats in, count them and latch the finished message.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q     <= '0;
            cnt_q    <= '0;
            msg      <= '0;
            msg_done <= 1'b0;
        end else begin
            msg_done <= 1'b0;
            if (take) begin
                sh_q <= sh_next;
                if (cnt_next == CNT_W'(NBEATS)) begin
                    cnt_q    <= '0;
                    msg      <= sh_next[SH_W-1 -: MSG_W];
                    msg_done <= 1'b1;
                end else begin
                    cnt_q <= cnt_next;
                end
            end
        end
    end
endmodule

// File: rtl/cnf_way_filter.sv
// One way's filter: masked tag compare, private exclusion and state filter.
// Assumes the action flags are mutually exclusive and that en is high only
// in the decision cycle.
module cnf_way_filter #(
    parameter int TAG_W = 19
) (
    input  logic             en,
    input  logic             act_own_inv,
    input  logic             act_own_dgr,
    input  logic             act_shr_inv,
    input  logic [TAG_W-1:0] key_tag,
    input  logic [TAG_W-1:0] cmp_mask,
    input  logic [TAG_W-1:0] tag,
    input  logic [1:0]       state,
    input  logic             priv,
    output logic             inv,
    output logic             dgr,
    output logic             own_hit
);
    import cnf_pkg::*;

    logic tag_ok;
    logic is_owner;
    logic is_sharer;
    logic eligible;

    // Classify the way and combine the filters into strobes.
    always_comb begin
        tag_ok    = ((tag ^ key_tag) & cmp_mask) == '0;
        is_owner  = (state == ST_E) || (state == ST_M);
        is_sharer = (state == ST_S);
        eligible  = en && tag_ok && !priv;
        inv       = eligible && ((act_own_inv && is_owner) || (act_shr_inv && is_sharer));
        dgr       = eligible && act_own_dgr && is_owner;
        own_hit   = eligible && is_owner && (act_own_inv || act_own_dgr);
    end
endmodule

// File: rtl/cnf_fwd_pick.sv
// Picks the lowest-numbered way from a hit vector as a one-hot result.
// Assumes nothing about how many bits of the input are set.
module cnf_fwd_pick #(
    parameter int WAYS = 4
) (
    input  logic [WAYS-1:0] hits,
    output logic [WAYS-1:0] pick,
    output logic            any
);
    // Scan upward and keep only the first set bit.
    always_comb begin
        pick = '0;
        any  = 1'b0;
        for (int w = 0; w < WAYS; w++) begin
            if (hits[w] && !any) begin
                pick[w] = 1'b1;
                any     = 1'b1;
            end
        end
    end
endmodule

// File: rtl/coh_notify_filter.sv
// Receiver for broadcast coherence notifications at one private cache.
// Rebuilds a message from serial beats, presents its set for lookup, and in
// the decision cycle filters every way of that set by address, state and
// private flag. FWD_MODE selects the full-address forwarding format instead
// of the compact index-plus-extra-bits format.
// Assumes the cache returns the set's tags, states and flags in the cycle
// that lookup_valid is high.
module coh_notify_filter #(
    parameter int WAYS       = 4,
    parameter int SETS       = 128,
    parameter int LINE_BYTES = 64,
    parameter int PA_W       = 32,
    parameter int EXTRA_W    = 5,
    parameter int BEAT_W     = 3,
    parameter int ID_W       = 4,
    parameter bit FWD_MODE   = 1'b0
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 beat_valid,
    input  logic                                 beat_sop,
    input  logic [BEAT_W-1:0]                    beat_data,
    output logic                                 lookup_valid,
    output logic [$clog2(SETS)-1:0]              lookup_set,
    input  logic [WAYS*(PA_W-$clog2(LINE_BYTES)-$clog2(SETS))-1:0] way_tag,
    input  logic [2*WAYS-1:0]                    way_state,
    input  logic [WAYS-1:0]                      way_private,
    output logic [WAYS-1:0]                      inv_way,
    output logic [WAYS-1:0]                      dgr_way,
    output logic                                 fwd_valid,
    output logic [WAYS-1:0]                      fwd_way,
    output logic [ID_W-1:0]                      fwd_id,
    output logic                                 fwd_inval
);
    import cnf_pkg::*;

    localparam int OFF_W = $clog2(LINE_BYTES);
    localparam int IDX_W = $clog2(SETS);
    localparam int TAG_W = PA_W - OFF_W - IDX_W;
    localparam int PAY_W = FWD_MODE ? (ID_W + TAG_W + IDX_W) : (IDX_W + EXTRA_W);
    localparam int MSG_W = CODE_W + PAY_W;

    logic               done;
    logic [MSG_W-1:0]   msg;
    logic [CODE_W-1:0]  code;
    logic [TAG_W-1:0]   key_tag;
    logic [TAG_W-1:0]   cmp_mask;
    logic               act_own_inv;
    logic               act_own_dgr;
    logic               act_shr_inv;
    logic [WAYS-1:0]    own_hit;
    logic [WAYS-1:0]    pick;
    logic               pick_any;

    cnf_deser #(
        .BEAT_W (BEAT_W),
        .MSG_W  (MSG_W)
    ) deser_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .beat_valid (beat_valid),
        .beat_sop   (beat_sop),
        .beat_data  (beat_data),
        .msg_done   (done),
        .msg        (msg)
    );

    assign code         = msg[MSG_W-1 -: CODE_W];
    assign lookup_valid = done;

    // Field layout and action-code meaning differ between the two formats.
    if (FWD_MODE) begin : g_fwd_fmt
        assign lookup_set  = msg[IDX_W-1:0];
        assign key_tag     = msg[IDX_W+TAG_W-1:IDX_W];
        assign cmp_mask    = '1;
        assign act_shr_inv = (code == 2'b00);
        assign act_own_dgr = (code == 2'b01);
        assign act_own_inv = (code == 2'b10);

        cnf_fwd_pick #(.WAYS(WAYS)) pick_i (
            .hits (own_hit),
            .pick (pick),
            .any  (pick_any)
        );

        assign fwd_valid = pick_any;
        assign fwd_way   = pick;
        assign fwd_id    = pick_any ? msg[MSG_W-CODE_W-1 -: ID_W] : '0;
        assign fwd_inval = pick_any && act_own_inv;
    end else begin : g_compact_fmt
        assign lookup_set  = msg[MSG_W-CODE_W-1 -: IDX_W];
        assign key_tag     = TAG_W'(msg[EXTRA_W-1:0]);
        assign cmp_mask    = TAG_W'({EXTRA_W{1'b1}});
        assign act_own_inv = (code == 2'b00);
        assign act_shr_inv = (code == 2'b01);
        assign act_own_dgr = (code == 2'b10);
        assign pick        = '0;
        assign pick_any    = 1'b0;
        assign fwd_valid   = 1'b0;
        assign fwd_way     = '0;
        assign fwd_id      = '0;
        assign fwd_inval   = 1'b0;
    end

    // One filter per way of the set.
    for (genvar w = 0; w < WAYS; w++) begin : g_way
        cnf_way_filter #(.TAG_W(TAG_W)) filt_i (
            .en          (done),
            .act_own_inv (act_own_inv),
            .act_own_dgr (act_own_dgr),
            .act_shr_inv (act_shr_inv),
            .key_tag     (key_tag),
            .cmp_mask    (cmp_mask),
            .tag         (way_tag[w*TAG_W +: TAG_W]),
            .state       (way_state[2*w +: 2]),
            .priv        (way_private[w]),
            .inv         (inv_way[w]),
            .dgr         (dgr_way[w]),
            .own_hit     (own_hit[w])
        );
    end
endmodule

// File: rtl/cnf_chk.sv
// Property checker for coh_notify_filter, attached by bind below.
// Assumes the two-bit state encoding from cnf_pkg.
module cnf_chk #(
    parameter int WAYS = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lookup_valid,
    input logic [WAYS-1:0]   inv_way,
    input logic [WAYS-1:0]   dgr_way,
    input logic [2*WAYS-1:0] way_state,
    input logic [WAYS-1:0]   way_private,
    input logic              fwd_valid,
    input logic [WAYS-1:0]   fwd_way
);
    import cnf_pkg::*;

    AST_STROBE_NEEDS_MSG: assert property (@(posedge clk) disable iff (!rst_n)
        ((inv_way != '0) || (dgr_way != '0) || fwd_valid) |-> lookup_valid); // R2
    AST_LOOKUP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        lookup_valid |=> !lookup_valid); // R2
    AST_PRIV_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
        ((inv_way | dgr_way | fwd_way) & way_private) == '0); // R8
    AST_NO_DUAL_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_way & dgr_way) == '0); // R11
    AST_FWD_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_valid |-> ($countones(fwd_way) == 1)); // R10
    AST_FWD_WAY_STROBED: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_valid |-> ((fwd_way & (inv_way | dgr_way)) == fwd_way)); // R10

    for (genvar w = 0; w < WAYS; w++) begin : g_way_chk
        AST_DGR_OWNER_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
            dgr_way[w] |-> (way_state[2*w +: 2] == ST_E || way_state[2*w +: 2] == ST_M)); // R6
        AST_INV_NOT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
            inv_way[w] |-> (way_state[2*w +: 2] != ST_I)); // R7
    end
endmodule

bind coh_notify_filter cnf_chk #(.WAYS(WAYS)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .lookup_valid (lookup_valid),
    .inv_way      (inv_way),
    .dgr_way      (dgr_way),
    .way_state    (way_state),
    .way_private  (way_private),
    .fwd_valid    (fwd_valid),
    .fwd_way      (fwd_way)
);

// File: tb/coh_notify_filter_tb_top.sv
// Bench: one compact-format and one forwarding-format instance share the
// per-way inputs; each message is checked against a bench model.
module coh_notify_filter_tb_top;
    localparam int TW = 19;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic [4*TW-1:0] way_tag = '0;
    logic [7:0]      way_state = '0;
    logic [3:0]      way_private = '0;

    logic       c_valid = 0, c_sop = 0;
    logic [2:0] c_data = '0;
    logic       c_lv;
    logic [6:0] c_set;
    logic [3:0] c_inv, c_dgr, c_fway, c_fid;
    logic       c_fv, c_finv;

    logic       f_valid = 0, f_sop = 0;
    logic [2:0] f_data = '0;
    logic       f_lv;
    logic [6:0] f_set;
    logic [3:0] f_inv, f_dgr, f_fway, f_fid;
    logic       f_fv, f_finv;

    int n_cmp = 0;
    int n_bad = 0;

    coh_notify_filter dut_i (
        .clk(clk), .rst_n(rst_n), .beat_valid(c_valid), .beat_sop(c_sop),
        .beat_data(c_data), .lookup_valid(c_lv), .lookup_set(c_set),
        .way_tag(way_tag), .way_state(way_state), .way_private(way_private),
        .inv_way(c_inv), .dgr_way(c_dgr), .fwd_valid(c_fv), .fwd_way(c_fway),
        .fwd_id(c_fid), .fwd_inval(c_finv)
    );

    coh_notify_filter #(.FWD_MODE(1'b1)) dut_fwd_i (
        .clk(clk), .rst_n(rst_n), .beat_valid(f_valid), .beat_sop(f_sop),
        .beat_data(f_data), .lookup_valid(f_lv), .lookup_set(f_set),
        .way_tag(way_tag), .way_state(way_state), .way_private(way_private),
        .inv_way(f_inv), .dgr_way(f_dgr), .fwd_valid(f_fv), .fwd_way(f_fway),
        .fwd_id(f_fid), .fwd_inval(f_finv)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_way(input int w, input logic [TW-1:0] t, input logic [1:0] st, input logic pv);
        way_tag[w*TW +: TW] = t;
        way_state[2*w +: 2] = st;
        way_private[w]      = pv;
    endtask

    // Expected outcome from the requirements (R4..R10).
    function automatic void model(input bit fm, input logic [1:0] h, input logic [TW-1:0] key,
                                  output logic [3:0] e_inv, output logic [3:0] e_dgr,
                                  output logic [3:0] e_fway, output logic e_fv, output logic e_finv);
        logic oi, od, si;
        oi = fm ? (h == 2'd2) : (h == 2'd0);
        od = fm ? (h == 2'd1) : (h == 2'd2);
        si = fm ? (h == 2'd0) : (h == 2'd1);
        e_inv = '0; e_dgr = '0; e_fway = '0; e_fv = 1'b0;
        for (int w = 0; w < 4; w++) begin
            logic [TW-1:0] t;
            logic [1:0] st;
            logic m, own, shr, ok;
            t   = way_tag[w*TW +: TW];
            st  = way_state[2*w +: 2];
            m   = fm ? (t == key) : (t[4:0] == key[4:0]);
            own = (st == 2'b10) || (st == 2'b11);
            shr = (st == 2'b01);
            ok  = m && !way_private[w];
            e_inv[w] = ok && ((oi && own) || (si && shr));
            e_dgr[w] = ok && od && own;
            if (fm && ok && own && (oi || od) && !e_fv) begin
                e_fv = 1'b1;
                e_fway[w] = 1'b1;
            end
        end
        e_finv = e_fv && oi;
    endfunction

    // Drive beats of one message; optionally leave the channel open.
    task automatic drive(input bit fm, input logic [1:0] h, input logic [6:0] idx,
                         input logic [TW-1:0] key, input logic [3:0] id, input int nbeats);
        logic [32:0] v;
        int nb;
        nb = fm ? 11 : 5;
        v  = fm ? {h, id, key, idx, 1'b0} : {18'd0, h, idx, key[4:0], 1'b0};
        for (int k = 0; k < nbeats; k++) begin
            @(negedge clk);
            if (fm) begin f_valid = 1; f_sop = (k == 0); f_data = v[nb*3-1-3*k -: 3]; end
            else    begin c_valid = 1; c_sop = (k == 0); c_data = v[nb*3-1-3*k -: 3]; end
        end
    endtask

    task automatic check_decision(input bit fm, input logic [1:0] h, input logic [6:0] idx,
                                  input logic [TW-1:0] key, input logic [3:0] id);
        logic [3:0] e_inv, e_dgr, e_fway;
        logic e_fv, e_finv;
        model(fm, h, key, e_inv, e_dgr, e_fway, e_fv, e_finv);
        if (fm) begin
            check("R2 lookup_valid", f_lv, 1);
            check("R2 lookup_set", f_set, idx);
            check("R9 inv_way", f_inv, e_inv);
            check("R9 dgr_way", f_dgr, e_dgr);
            check("R10 fwd_valid", f_fv, e_fv);
            check("R10 fwd_way", f_fway, e_fway);
            check("R10 fwd_id", f_fid, e_fv ? id : 4'd0);
            check("R10 fwd_inval", f_finv, e_finv);
        end else begin
            check("R2 lookup_valid", c_lv, 1);
            check("R2 lookup_set", c_set, idx);
            check("R5 inv_way", c_inv, e_inv);
            check("R6 dgr_way", c_dgr, e_dgr);
            check("R4 no forward in compact mode", c_fv, 0);
        end
    endtask

    // Full message, then decision check, then the one-cycle pulse check.
    task automatic send(input bit fm, input logic [1:0] h, input logic [6:0] idx,
                        input logic [TW-1:0] key, input logic [3:0] id);
        drive(fm, h, idx, key, id, fm ? 11 : 5);
        @(negedge clk);
        f_valid = 0; f_sop = 0; c_valid = 0; c_sop = 0;
        check_decision(fm, h, idx, key, id);
        @(negedge clk);
        check("R11 strobes last one cycle", fm ? {f_lv, f_inv, f_dgr, f_fv} : {c_lv, c_inv, c_dgr, c_fv}, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired, actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset quiet compact", {c_lv, c_inv, c_dgr}, 0);
        check("R1 reset quiet forward", {f_lv, f_inv, f_dgr, f_fv}, 0);

        // R6 / R4: one way per state, all low bits matching.
        set_way(0, 19'h00011, 2'b00, 0);
        set_way(1, 19'h00031, 2'b01, 0);
        set_way(2, 19'h00051, 2'b10, 0);
        set_way(3, 19'h00071, 2'b11, 0);
        send(0, 2'b00, 7'h15, 19'h00011, 0);   // R6 owner invalidate -> ways 2,3
        send(0, 2'b10, 7'h2a, 19'h00011, 0);   // R6 downgrade -> ways 2,3
        send(0, 2'b01, 7'h7f, 19'h00011, 0);   // R7 sharer invalidate -> way 1
        send(0, 2'b11, 7'h01, 19'h00011, 0);   // R4 unused code -> nothing

        // R5: tags equal in the low five bits only; compact hits all sharers.
        for (int w = 0; w < 4; w++) set_way(w, 19'h00003 | (w << 9), 2'b01, 0);
        send(0, 2'b01, 7'h40, 19'h00003, 0);
        send(1, 2'b00, 7'h40, 19'h00203, 0);   // R9 full compare -> way 1 only
        send(0, 2'b01, 7'h40, 19'h00004, 0);   // R5 extra bits differ -> nothing

        // R8: private ways excluded.
        for (int w = 0; w < 4; w++) set_way(w, 19'h12345, 2'b11, w[0] == 1'b0);
        send(0, 2'b00, 7'h05, 19'h12345, 0);
        send(1, 2'b10, 7'h05, 19'h12345, 4'h9); // R10 lowest non-private way 1

        // R10: forward downgrade and forward invalidate, lowest owner chosen.
        set_way(0, 19'h12345, 2'b01, 0);
        set_way(1, 19'h00000, 2'b11, 0);
        set_way(2, 19'h12345, 2'b10, 0);
        set_way(3, 19'h12345, 2'b11, 0);
        send(1, 2'b01, 7'h33, 19'h12345, 4'h6);
        send(1, 2'b10, 7'h33, 19'h12345, 4'hc);
        send(1, 2'b11, 7'h33, 19'h12345, 4'h3); // R9 unused code
        set_way(2, 19'h12345, 2'b00, 0);
        set_way(3, 19'h12345, 2'b01, 0);
        send(1, 2'b10, 7'h33, 19'h12345, 4'h3); // R10 no owner -> no forward

        // R3: stray beats while idle are ignored.
        for (int k = 0; k < 7; k++) begin
            @(negedge clk);
            c_valid = 1; c_sop = 0; c_data = 3'b111;
            check("R3 stray beat ignored", c_lv, 0);
        end
        @(negedge clk); c_valid = 0;
        check("R3 stray beat ignored", c_lv, 0);
        // R3: a new opening beat restarts the message.
        drive(0, 2'b00, 7'h11, 19'h00011, 0, 3);
        drive(0, 2'b01, 7'h22, 19'h00005, 0, 4);
        @(negedge clk);
        check("R3 restart no early decision", c_lv, 0);
        c_valid = 0;
        for (int w = 0; w < 4; w++) set_way(w, 19'h00005, 2'b01, 0);
        send(0, 2'b01, 7'h22, 19'h00005, 0);

        // Back to back: next opening beat lands in the decision cycle.
        drive(0, 2'b01, 7'h0e, 19'h00005, 0, 5);
        drive(0, 2'b00, 7'h0f, 19'h00005, 0, 1);
        check_decision(0, 2'b01, 7'h0e, 19'h00005, 0);
        drive(0, 2'b00, 7'h0f, 19'h00005, 0, 5);
        @(negedge clk); c_valid = 0; c_sop = 0;
        check_decision(0, 2'b00, 7'h0f, 19'h00005, 0);

        // Random compact messages (R4..R8, R11).
        for (int i = 0; i < 60; i++) begin
            logic [TW-1:0] key;
            key = TW'($urandom);
            for (int w = 0; w < 4; w++)
                set_way(w, ($urandom % 2) ? {TW'($urandom) & 19'h7ffe0} | key[4:0] : TW'($urandom),
                        2'($urandom), ($urandom % 4) == 0);
            send(0, 2'($urandom), 7'($urandom), key, 0);
        end

        // Random forwarding messages (R8..R11).
        for (int i = 0; i < 40; i++) begin
            logic [TW-1:0] key;
            key = TW'($urandom);
            for (int w = 0; w < 4; w++)
                set_way(w, ($urandom % 2) ? key : TW'($urandom), 2'($urandom), ($urandom % 4) == 0);
            send(1, 2'($urandom), 7'($urandom), key, 4'($urandom));
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule